// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link for an 8K x 8 nonvolatile memory. It runs on a fast system clock. It oversamples the serial clock, chip select, pause and data lines, then decodes the traffic into simple strobes for a memory back end. The back end holds the array, the protection policy and the write timing. The front end only turns bit streams into requests and shifts read data back out.

Each transaction starts with a one-byte command. Array commands are followed by a two-byte address, and the top three address bits are dropped. Read data comes from a combinational read port: the front end holds the address steady and loads the byte when the first bit must appear. Writes produce one request for each complete data byte. A pause input can freeze a transaction part way through, and the transfer later carries on from the same bit.

Top module: `spi_mem_frontend`

## Requirements
- R1: A command byte of 8'h06 gives one `wel_set` pulse and 8'h04 gives one `wel_clr` pulse, once all 8 command bits are in. Any further bits before deselect are ignored.
- R2: Input bits are taken on the rising serial clock edge and output bits change after the falling edge. Transfers are MSB first, and the idle clock level may be low or high.
- R3: Command 8'h03 is followed by a 16-bit address, of which the low 13 bits are used. Each returned byte is `mem_rdata` for the address then on `mem_addr`, and successive bytes come from successive addresses.
- R4: The read address steps from 13'h1FFF to 13'h0000, so a read can go on without end.
- R5: Command 8'h05 returns `stat_data` on SO straight after the command byte, and the byte is repeated for as long as clocks continue.
- R6: Command 8'h02 is followed by a 16-bit address. Each complete data byte then gives a `wr_req` pulse with `wr_addr`/`wr_data`. Between bytes only the low 5 address bits advance, and they wrap inside the 32-byte page.
- R7: Command 8'h01 followed by one data byte gives one `wst_req` pulse with that byte on `wr_data`. Later bits in the same selection are ignored.
- R8: While chip select is high, `so_oe` is low. Deselecting part way through a command discards the partial bits.
- R9: After reset, no command is decoded until chip select has been seen high and then low.
- R10: An opcode outside the six listed makes the block ignore every further bit until deselect. No strobe is given and SO stays off.
- R11: A pause begins when the pause input falls while the serial clock is low, and ends when it rises while the clock is low. During a pause, clock and data are ignored and `so_oe` is low. Afterwards shifting resumes at the same bit.
- R12: `so_oe` is high only during the output phase of a read or status read, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause request, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; low means high impedance |
| wel_set | output | 1 | Pulse: set write enable |
| wel_clr | output | 1 | Pulse: clear write enable |
| wst_req | output | 1 | Pulse: status write request, byte on wr_data |
| wr_req | output | 1 | Pulse: array byte write request |
| wr_addr | output | 13 | Array address of the write request |
| wr_data | output | 8 | Data of the write or status request |
| mem_addr | output | 13 | Current read address |
| mem_rd | output | 1 | Pulse: a byte was taken from mem_rdata |
| mem_rdata | input | 8 | Array byte at mem_addr (combinational) |
| stat_data | input | 8 | Status byte supplied by the back end |

## Verification
A pause can start in the same system cycle as a falling serial clock edge that loads the next read byte and steps the address. The bench provokes this by dropping the pause line in the same instant as the clock, at the first bit of a read byte. It also pauses in the middle of a byte, and in the middle of a write byte while SI and the clock toggle. The scoreboard then expects the byte stream to carry on unbroken, with no skipped or repeated address and no data corrupted by the toggles. The bench also expects `so_oe` to be low for the whole pause.

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              wst_req,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  input  logic [7:0]        stat_data
);
  typedef enum logic [2:0] {P_OPC, P_ADDR, P_WDAT, P_SDAT, P_OUT, P_IDLE} phase_t;

  logic [1:0] sck_m, cs_m, hold_m, si_m;
  logic sck_q, hold_q, armed, paused, is_rd, out_en;
  phase_t phase;
  logic [3:0] cnt;
  logic [2:0] ocnt;
  logic [ADDR_W-2:0] sh;
  logic [7:0] osh;
  logic [ADDR_W-1:0] addr;

  wire sck_s  = sck_m[1];
  wire cs_s   = cs_m[1];
  wire hold_s = hold_m[1];
  wire si_s   = si_m[1];
  wire active = armed & ~cs_s & ~paused;
  wire rise   = active & sck_s & ~sck_q;
  wire fall   = active & ~sck_s & sck_q;
  wire [ADDR_W-1:0] nxt = {sh, si_s};
  wire [7:0] byte_in = nxt[7:0];

  assign so       = osh[7];
  assign so_oe    = out_en & ~paused & ~cs_s;
  assign mem_addr = addr;
  assign mem_rd   = fall & (phase == P_OUT) & is_rd & (ocnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= '0; cs_m <= '0; hold_m <= 2'b11; si_m <= '0;
      sck_q <= 1'b0; hold_q <= 1'b1;
    end else begin
      sck_m <= {sck_m[0], sck};
      cs_m <= {cs_m[0], cs_n};
      hold_m <= {hold_m[0], hold_n};
      si_m <= {si_m[0], si};
      sck_q <= sck_s;
      hold_q <= hold_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; paused <= 1'b0; phase <= P_OPC; cnt <= '0; ocnt <= '0;
      sh <= '0; osh <= '0; addr <= '0; is_rd <= 1'b0; out_en <= 1'b0;
      wel_set <= 1'b0; wel_clr <= 1'b0; wst_req <= 1'b0; wr_req <= 1'b0;
      wr_addr <= '0; wr_data <= '0;
    end else begin
      wel_set <= 1'b0; wel_clr <= 1'b0; wst_req <= 1'b0; wr_req <= 1'b0;
      if (cs_s) begin
        armed <= 1'b1; paused <= 1'b0; phase <= P_OPC;
        cnt <= '0; ocnt <= '0; out_en <= 1'b0;
      end else begin
        if (!paused && hold_q && !hold_s && !sck_s) paused <= 1'b1;
        else if (paused && !hold_q && hold_s && !sck_s) paused <= 1'b0;
        if (rise) begin
          sh <= nxt[ADDR_W-2:0];
          cnt <= cnt + 4'd1;
          case (phase)
            P_OPC: if (cnt == 4'd7) begin
              cnt <= '0;
              case (byte_in)
                8'h06: begin wel_set <= 1'b1; phase <= P_IDLE; end
                8'h04: begin wel_clr <= 1'b1; phase <= P_IDLE; end
                8'h05: begin is_rd <= 1'b0; phase <= P_OUT; end
                8'h01: phase <= P_SDAT;
                8'h03: begin is_rd <= 1'b1; phase <= P_ADDR; end
                8'h02: begin is_rd <= 1'b0; phase <= P_ADDR; end
                default: phase <= P_IDLE;
              endcase
            end
            P_ADDR: if (cnt == 4'd15) begin
              cnt <= '0;
              addr <= nxt;
              phase <= is_rd ? P_OUT : P_WDAT;
            end
            P_WDAT: if (cnt == 4'd7) begin
              cnt <= '0;
              wr_req <= 1'b1;
              wr_addr <= addr;
              wr_data <= byte_in;
              addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
            end
            P_SDAT: if (cnt == 4'd7) begin
              wst_req <= 1'b1;
              wr_data <= byte_in;
              phase <= P_IDLE;
            end
            default: ;
          endcase
        end
        if (fall && phase == P_OUT) begin
          ocnt <= ocnt + 3'd1;
          if (ocnt == 3'd0) begin
            osh <= is_rd ? mem_rdata : stat_data;
            out_en <= 1'b1;
            if (is_rd) addr <= addr + ADDR_W'(1);
          end else begin
            osh <= {osh[6:0], 1'b0};
          end
        end
      end
    end
  end

  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set, wel_clr, wst_req, wr_req}));
  a_r4_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_addr == $past(mem_addr) + ADDR_W'(1));
  a_r6_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> addr[ADDR_W-1:PAGE_W] == $past(wr_addr[ADDR_W-1:PAGE_W]));
  a_r8_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !so_oe);
  a_r9_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !wel_set && !wel_clr && !wr_req && !wst_req && !so_oe);
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    paused && $past(paused) |-> $stable(phase) && $stable(cnt) && $stable(ocnt) && $stable(osh));
  a_r12_out_phase: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> phase == P_OUT);
endmodule

// File: tb/spi_mem_frontend_test.sv
module spi_mem_frontend_test;
  localparam int CLK_NS = 10;
  localparam int HALF = 8 * CLK_NS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck, cs_n, hold_n, si;
  logic so, so_oe, wel_set, wel_clr, wst_req, wr_req, mem_rd;
  logic [12:0] wr_addr, mem_addr;
  logic [7:0] wr_data, mem_rdata, stat_data;

  int checks = 0, fails = 0;
  int n_set = 0, n_clr = 0, n_wst = 0;
  logic [7:0] last_wst = '0;
  logic so_seen = 1'b0;
  logic cpol = 1'b0;
  bit done = 1'b0;

  logic [7:0]  exp_q[$], got_q[$];
  string       exp_tag[$], wtag[$];
  logic [20:0] exp_w[$];

  function automatic logic [7:0] memf(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b011};
  endfunction

  assign mem_rdata = memf(mem_addr);

  spi_mem_frontend uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .so(so), .so_oe(so_oe), .wel_set(wel_set), .wel_clr(wel_clr),
    .wst_req(wst_req), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .stat_data(stat_data)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
    if (wst_req) begin n_wst++; last_wst = wr_data; end
    if (so_oe) so_seen = 1'b1;
    if (got_q.size() > 0) begin
      logic [7:0] g;
      g = got_q.pop_front();
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", g, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(g == e, t, g, e);
      end
    end
    if (wr_req) begin
      if (exp_w.size() == 0) chk(1'b0, "R6 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        logic [20:0] e;
        string t;
        e = exp_w.pop_front();
        t = wtag.pop_front();
        chk({wr_addr, wr_data} == e, t, {wr_addr, wr_data}, e);
      end
    end
  end

  task automatic sbit(input logic mosi, output logic miso, input bit hold_here);
    sck = 1'b0;
    si = mosi;
    if (hold_here) begin
      hold_n = 1'b0;
      #(HALF);
      chk(so_oe == 1'b0, "R11 so_oe during pause", so_oe, 0);
      for (int k = 0; k < 3; k++) begin
        si = ~mosi; sck = 1'b1; #(HALF);
        sck = 1'b0; #(HALF);
      end
      si = mosi;
      hold_n = 1'b1;
    end
    #(HALF);
    miso = so_oe ? so : 1'b1;
    sck = 1'b1;
    #(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, input bit rx, input int hold_at);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      logic m;
      sbit(tx[i], m, i == hold_at);
      r[i] = m;
    end
    if (rx) got_q.push_back(r);
  endtask

  task automatic start();
    sck = cpol;
    #(HALF);
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic stop();
    sck = cpol;
    #(HALF);
    cs_n = 1'b1;
    #(3 * HALF);
  endtask

  task automatic expect_rd(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    exp_tag.push_back(t);
  endtask

  task automatic expect_wr(input logic [12:0] a, input logic [7:0] d);
    exp_w.push_back({a, d});
    wtag.push_back("R6 write request");
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    sck = 1'b0; cs_n = 1'b0; hold_n = 1'b1; si = 1'b0; stat_data = 8'h8C;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(so_oe == 1'b0, "R12 reset so_oe", so_oe, 0);

    // R9: selected from reset, no high-to-low yet
    xbyte(8'h06, 1'b0, -1);
    sck = 1'b0; #(2 * HALF);
    chk(n_set == 0, "R9 command before arming", n_set, 0);
    cs_n = 1'b1; #(3 * HALF);

    // R1
    start(); xbyte(8'h06, 1'b0, -1); xbyte(8'h04, 1'b0, -1); stop();
    chk(n_set == 1 && n_clr == 0, "R1 set write enable", n_set, 1);
    start(); xbyte(8'h04, 1'b0, -1); stop();
    chk(n_clr == 1, "R1 clear write enable", n_clr, 1);

    // R8: partial command discarded
    start();
    for (int i = 0; i < 4; i++) begin logic m; sbit(1'b0, m, 1'b0); end
    stop();
    chk(so_oe == 1'b0, "R8 so_oe deselected", so_oe, 0);
    start(); xbyte(8'h06, 1'b0, -1); stop();
    chk(n_set == 2, "R8 fresh command after deselect", n_set, 2);

    // R5 status read
    start(); xbyte(8'h05, 1'b0, -1);
    expect_rd(8'h8C, "R5 status byte");
    expect_rd(8'h8C, "R5 status repeat");
    xbyte(8'h00, 1'b1, -1); xbyte(8'h00, 1'b1, -1);
    stop();

    // R3/R4/R11 wrap read in idle-high clock mode, pauses mid-byte and at byte start
    cpol = 1'b1;
    start(); xbyte(8'h03, 1'b0, -1); xbyte(8'hFF, 1'b0, -1); xbyte(8'hFE, 1'b0, -1);
    expect_rd(memf(13'h1FFE), "R3 read first byte");
    expect_rd(memf(13'h1FFF), "R11 read after mid-byte pause");
    expect_rd(memf(13'h0000), "R4 read wrap");
    expect_rd(memf(13'h0001), "R2 read after wrap in idle-high mode");
    xbyte(8'h00, 1'b1, -1);
    xbyte(8'h00, 1'b1, 3);
    xbyte(8'h00, 1'b1, 7);
    xbyte(8'h00, 1'b1, -1);
    stop();
    cpol = 1'b0;
    sck = 1'b0; #(2 * HALF);
    chk(so_oe == 1'b0, "R8 so_oe after read", so_oe, 0);

    // R3 mid-range address with top bits set
    start(); xbyte(8'h03, 1'b0, -1); xbyte(8'hE1, 1'b0, -1); xbyte(8'h23, 1'b0, -1);
    expect_rd(memf(13'h0123), "R3 low 13 bits used");
    expect_rd(memf(13'h0124), "R3 sequential read");
    xbyte(8'h00, 1'b1, -1); xbyte(8'h00, 1'b1, -1);
    stop();

    // R6 page write with wrap, pause inside a data byte
    so_seen = 1'b0;
    expect_wr(13'h001E, 8'h11);
    expect_wr(13'h001F, 8'h22);
    expect_wr(13'h0000, 8'h33);
    start(); xbyte(8'h02, 1'b0, -1); xbyte(8'h20, 1'b0, -1); xbyte(8'h1E, 1'b0, -1);
    xbyte(8'h11, 1'b0, -1); xbyte(8'h22, 1'b0, 4); xbyte(8'h33, 1'b0, -1);
    stop();
    chk(so_seen == 1'b0, "R12 so_oe during write", so_seen, 0);

    // R7 status write, trailing bits ignored
    start(); xbyte(8'h01, 1'b0, -1); xbyte(8'h9C, 1'b0, -1); xbyte(8'h06, 1'b0, -1); stop();
    chk(n_wst == 1, "R7 one status request", n_wst, 1);
    chk(last_wst == 8'h9C, "R7 status data", last_wst, 8'h9C);
    chk(n_set == 2, "R7 trailing bits ignored", n_set, 2);

    // R10 unknown opcode
    so_seen = 1'b0;
    start(); xbyte(8'hA5, 1'b0, -1); xbyte(8'h06, 1'b0, -1); xbyte(8'h05, 1'b0, -1);
    xbyte(8'h00, 1'b0, -1); stop();
    chk(n_set == 2 && n_wst == 1, "R10 no strobe after unknown opcode", n_set, 2);
    chk(so_seen == 1'b0, "R10 SO off after unknown opcode", so_seen, 0);

    repeat (10) @(posedge clk);
    #1;
    chk(exp_q.size() == 0 && exp_w.size() == 0, "R3 all expected items seen",
        exp_q.size() + exp_w.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule